// File: doc/BRIEF.md
# SPI Receive Status and Interrupt Logic

This block keeps the receive-side status of an SPI peripheral: the receive-full, overrun and mode-fault flags, the holding register for the last accepted byte, and the two interrupt request lines. The serial shifter sends a one-cycle pulse when a byte has been assembled, together with that byte. A mode-fault detect line comes from the pin logic. The CPU bus side supplies strobes for a status-register read, a data-register read and a control-register write. It also supplies the enable bits for mode-fault detection, error interrupts, receive interrupts, transmit interrupts and the SPI as a whole.

The flags cannot be cleared by a single access. Software must first read status while a flag is set, which arms that flag's clear. The matching second access then drops the flag: a data-register read for receive-full and overrun, and a control-register write for mode-fault. When a byte arrives while the previous one is still unread, the new byte is discarded and only the overrun flag records the loss.

Top module: `spi_rx_status`

## Requirements
- R1: A byte-received pulse while receive-full is 0 sets receive-full and loads the byte into the data register. Both are visible after the next clock edge.
- R2: Receive-full clears only on a data-register read that follows an earlier status read made while receive-full was 1. A data-register read with no such prior status read leaves the flag set.
- R3: A byte-received pulse while receive-full is 1 sets overrun. The data register keeps the earlier byte and the new byte is lost.
- R4: Overrun clears on a data-register read that follows a status read made while overrun was 1.
- R5: A mode-fault detect sets the mode-fault flag only while the mode-fault enable is 1.
- R6: Dropping the mode-fault enable leaves a set mode-fault flag set. The flag clears on a control-register write that follows a status read made while the flag was 1.
- R7: The receiver/error request equals (receive-full AND receive-interrupt enable) OR (error-interrupt enable AND (overrun OR mode-fault)). It is combinational from the flags and enables.
- R8: The transmitter request equals transmit-empty AND transmit-interrupt enable AND SPI enable. It is combinational.
- R9: When a set event and an armed clear for the same flag occur in one cycle, the flag stays 1. For example, a data read coincides with a byte arrival while overrun is armed.
- R10: While rst_n is low, all flags and clear arms are 0 and the data register is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_done_i | input | 1 | One-cycle pulse: a byte has been received |
| rx_byte_i | input | DW | Received byte, valid with rx_done_i |
| mode_fault_i | input | 1 | Mode-fault condition detected |
| stat_rd_i | input | 1 | CPU read of the status register |
| data_rd_i | input | 1 | CPU read of the data register |
| ctrl_wr_i | input | 1 | CPU write of the control register |
| modf_en_i | input | 1 | Mode-fault detection enable |
| err_ie_i | input | 1 | Error interrupt enable (overrun and mode-fault) |
| rx_ie_i | input | 1 | Receive interrupt enable |
| tx_ie_i | input | 1 | Transmit interrupt enable |
| spi_en_i | input | 1 | SPI enable |
| tx_empty_i | input | 1 | Transmit-empty flag |
| rx_data_o | output | DW | Data register contents |
| rx_full_o | output | 1 | Receive-full flag |
| ovr_o | output | 1 | Overrun flag |
| modf_o | output | 1 | Mode-fault flag |
| tx_irq_o | output | 1 | Transmitter interrupt request |
| rxerr_irq_o | output | 1 | Receiver/error interrupt request |

## Verification
The hardest case to reach is a set event landing in the same cycle as an armed clear of that same flag. For overrun this needs two unread bytes, then a status read, then a data read that coincides with a third byte. A directed sequence builds this exact pattern. Random traffic with dense strobes then explores further interleavings of arm, clear and set against a bench model.

// File: rtl/spi_rxst_pkg.sv
package spi_rxst_pkg;
  localparam int NFLAG = 3;
  typedef enum int {
    FLG_FULL = 0,
    FLG_OVR  = 1,
    FLG_MODF = 2
  } flag_idx_e;
endpackage

// File: rtl/spi_rxst_flag.sv
// One status flag with a two-step clear: a status read while set arms it,
// the next clear strobe drops it. A set event in the same cycle wins.
module spi_rxst_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic stat_rd_i,
  input  logic clr_strobe_i,
  output logic flag_o
);
  logic flag_q, flag_d;
  logic arm_q, arm_d;
  logic clr_fire;

  always_comb begin
    clr_fire = arm_q && clr_strobe_i;
    flag_d   = flag_q;
    arm_d    = arm_q;
    if (clr_fire) begin
      flag_d = 1'b0;
      arm_d  = 1'b0;
    end else if (stat_rd_i && flag_q) begin
      arm_d = 1'b1;
    end
    if (set_i) begin
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;

  AST_ARM_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q |-> flag_q); // R2
  AST_FALL_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> ($past(arm_q) && $past(clr_strobe_i))); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q); // R9
endmodule

// File: rtl/spi_rxst_hold.sv
// Receive data holding register.
module spi_rxst_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o
);
  logic [DW-1:0] data_q, data_d;

  always_comb begin
    data_d = data_q;
    if (load_i) data_d = din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  assign dout_o = data_q;

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(data_q)); // R3
endmodule

// File: rtl/spi_rxst_irq.sv
// Interrupt request combining.
module spi_rxst_irq (
  input  logic full_i,
  input  logic ovr_i,
  input  logic modf_i,
  input  logic err_ie_i,
  input  logic rx_ie_i,
  input  logic tx_ie_i,
  input  logic spi_en_i,
  input  logic tx_empty_i,
  output logic tx_irq_o,
  output logic rxerr_irq_o
);
  logic err_any;

  always_comb begin
    err_any     = ovr_i || modf_i;
    rxerr_irq_o = (full_i && rx_ie_i) || (err_ie_i && err_any);
    tx_irq_o    = tx_empty_i && tx_ie_i && spi_en_i;
  end
endmodule

// File: rtl/spi_rx_status.sv
module spi_rx_status
  import spi_rxst_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_done_i,
  input  logic [DW-1:0] rx_byte_i,
  input  logic          mode_fault_i,
  input  logic          stat_rd_i,
  input  logic          data_rd_i,
  input  logic          ctrl_wr_i,
  input  logic          modf_en_i,
  input  logic          err_ie_i,
  input  logic          rx_ie_i,
  input  logic          tx_ie_i,
  input  logic          spi_en_i,
  input  logic          tx_empty_i,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_full_o,
  output logic          ovr_o,
  output logic          modf_o,
  output logic          tx_irq_o,
  output logic          rxerr_irq_o
);
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flag_clr;
  logic [NFLAG-1:0] flag_q;
  logic             accept;

  always_comb begin
    accept             = rx_done_i && !flag_q[FLG_FULL];
    flag_set           = '0;
    flag_set[FLG_FULL] = accept;
    flag_set[FLG_OVR]  = rx_done_i && flag_q[FLG_FULL];
    flag_set[FLG_MODF] = mode_fault_i && modf_en_i;
  end

  for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
    if (gi == int'(FLG_MODF)) begin : g_ctrl_clr
      assign flag_clr[gi] = ctrl_wr_i;
    end else begin : g_data_clr
      assign flag_clr[gi] = data_rd_i;
    end
    spi_rxst_flag u_flag (
      .clk          (clk),
      .rst_n        (rst_n),
      .set_i        (flag_set[gi]),
      .stat_rd_i    (stat_rd_i),
      .clr_strobe_i (flag_clr[gi]),
      .flag_o       (flag_q[gi])
    );
  end

  spi_rxst_hold #(.DW(DW)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .din_i  (rx_byte_i),
    .dout_o (rx_data_o)
  );

  spi_rxst_irq u_irq (
    .full_i      (flag_q[FLG_FULL]),
    .ovr_i       (flag_q[FLG_OVR]),
    .modf_i      (flag_q[FLG_MODF]),
    .err_ie_i    (err_ie_i),
    .rx_ie_i     (rx_ie_i),
    .tx_ie_i     (tx_ie_i),
    .spi_en_i    (spi_en_i),
    .tx_empty_i  (tx_empty_i),
    .tx_irq_o    (tx_irq_o),
    .rxerr_irq_o (rxerr_irq_o)
  );

  assign rx_full_o = flag_q[FLG_FULL];
  assign ovr_o     = flag_q[FLG_OVR];
  assign modf_o    = flag_q[FLG_MODF];

  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_i && rx_full_o) |=> (ovr_o && $stable(rx_data_o))); // R3
  AST_MODF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf_o) |-> $past(modf_en_i)); // R5
  AST_RX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done_i && !rx_full_o) |=> (rx_full_o && rx_data_o == $past(rx_byte_i))); // R1
  AST_TX_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq_o |-> spi_en_i); // R8
endmodule

// File: tb/spi_rx_status_tb.sv
module spi_rx_status_tb_top;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic rx_done, mode_fault, stat_rd, data_rd, ctrl_wr;
  logic modf_en, err_ie, rx_ie, tx_ie, spi_en, tx_empty;
  logic [DW-1:0] rx_byte;
  logic [DW-1:0] rx_data;
  logic rx_full, ovr, modf, tx_irq, rxerr_irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference state
  logic m_full, m_ovr, m_modf, a_full, a_ovr, a_modf;
  logic [DW-1:0] m_data;

  always #5 clk = ~clk;

  spi_rx_status #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_done_i(rx_done), .rx_byte_i(rx_byte),
    .mode_fault_i(mode_fault), .stat_rd_i(stat_rd), .data_rd_i(data_rd),
    .ctrl_wr_i(ctrl_wr), .modf_en_i(modf_en), .err_ie_i(err_ie),
    .rx_ie_i(rx_ie), .tx_ie_i(tx_ie), .spi_en_i(spi_en), .tx_empty_i(tx_empty),
    .rx_data_o(rx_data), .rx_full_o(rx_full), .ovr_o(ovr), .modf_o(modf),
    .tx_irq_o(tx_irq), .rxerr_irq_o(rxerr_irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic exp_rxerr();
    return (m_full && rx_ie) || (err_ie && (m_ovr || m_modf));
  endfunction

  function automatic logic exp_tx();
    return tx_empty && tx_ie && spi_en;
  endfunction

  // one flag of the reference: returns {flag, arm}
  function automatic logic [1:0] ref_flag(input logic f, input logic a, input logic set,
                                          input logic rd, input logic strobe);
    logic nf, na;
    nf = f; na = a;
    if (a && strobe) begin nf = 1'b0; na = 1'b0; end
    else if (rd && f) na = 1'b1;
    if (set) nf = 1'b1;
    return {nf, na};
  endfunction

  task automatic model_step();
    logic [1:0] r;
    logic s_full, s_ovr, s_modf;
    s_full = rx_done && !m_full;
    s_ovr  = rx_done && m_full;
    s_modf = mode_fault && modf_en;
    if (s_full) m_data = rx_byte;
    r = ref_flag(m_full, a_full, s_full, stat_rd, data_rd); {m_full, a_full} = r;
    r = ref_flag(m_ovr,  a_ovr,  s_ovr,  stat_rd, data_rd); {m_ovr,  a_ovr}  = r;
    r = ref_flag(m_modf, a_modf, s_modf, stat_rd, ctrl_wr); {m_modf, a_modf} = r;
  endtask

  task automatic idle();
    rx_done = 0; mode_fault = 0; stat_rd = 0; data_rd = 0; ctrl_wr = 0;
  endtask

  // inputs are driven at a negedge before this is called
  task automatic cycle();
    #1;
    chk("R7", "rxerr_irq", rxerr_irq, exp_rxerr());
    chk("R8", "tx_irq", tx_irq, exp_tx());
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R2", "rx_full", rx_full, m_full);
    chk("R4", "ovr", ovr, m_ovr);
    chk("R6", "modf", modf, m_modf);
    chk("R3", "rx_data", rx_data, m_data);
  endtask

  task automatic op(input logic rd_done, input logic [DW-1:0] b, input logic sr,
                    input logic dr, input logic cw, input logic mf);
    rx_done = rd_done; rx_byte = b; stat_rd = sr; data_rd = dr;
    ctrl_wr = cw; mode_fault = mf;
    cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5A17;
    void'($urandom(seed));
    rst_n = 0; idle(); rx_byte = 8'hFF;
    modf_en = 1; err_ie = 1; rx_ie = 1; tx_ie = 1; spi_en = 1; tx_empty = 1;
    m_full = 0; m_ovr = 0; m_modf = 0; a_full = 0; a_ovr = 0; a_modf = 0; m_data = '0;
    repeat (3) @(negedge clk);
    chk("R10", "rst full", rx_full, 0);
    chk("R10", "rst ovr", ovr, 0);
    chk("R10", "rst modf", modf, 0);
    chk("R10", "rst data", rx_data, 0);
    rst_n = 1;
    @(negedge clk);

    // R1: byte accepted
    op(1, 8'hA1, 0, 0, 0, 0);
    chk("R1", "full after byte", rx_full, 1);
    chk("R1", "data loaded", rx_data, 8'hA1);
    // R2: data read without prior status read does not clear
    op(0, 0, 0, 1, 0, 0);
    chk("R2", "full kept without arm", rx_full, 1);
    // R3: second byte overruns
    op(1, 8'hB2, 0, 0, 0, 0);
    chk("R3", "ovr set", ovr, 1);
    chk("R3", "data kept", rx_data, 8'hA1);
    // R9: arm, then data read together with a new byte
    op(0, 0, 1, 0, 0, 0);
    op(1, 8'hC3, 0, 1, 0, 0);
    chk("R9", "ovr stays on coincident set", ovr, 1);
    chk("R2", "full cleared by sequence", rx_full, 0);
    chk("R3", "lost byte not stored", rx_data, 8'hA1);
    // R4: clear overrun
    op(0, 0, 1, 0, 0, 0);
    op(0, 0, 0, 1, 0, 0);
    chk("R4", "ovr cleared", ovr, 0);
    // R5: mode fault gated by enable
    modf_en = 0;
    op(0, 0, 0, 0, 0, 1);
    chk("R5", "modf blocked", modf, 0);
    modf_en = 1;
    op(0, 0, 0, 0, 0, 1);
    chk("R5", "modf set", modf, 1);
    // R6: disabling keeps flag, status read + ctrl write clears
    modf_en = 0;
    op(0, 0, 0, 0, 0, 0);
    chk("R6", "modf kept after disable", modf, 1);
    op(0, 0, 1, 0, 0, 0);
    op(0, 0, 0, 0, 1, 0);
    chk("R6", "modf cleared", modf, 0);
    op(0, 0, 0, 0, 0, 1);
    chk("R6", "modf not reset while disabled", modf, 0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      modf_en  = ($urandom % 4) != 0;
      err_ie   = $urandom % 2;
      rx_ie    = $urandom % 2;
      tx_ie    = $urandom % 2;
      spi_en   = $urandom % 2;
      tx_empty = $urandom % 2;
      op(($urandom % 10) < 3, DW'($urandom), ($urandom % 10) < 3,
         ($urandom % 10) < 3, ($urandom % 10) < 1, ($urandom % 10) < 1);
    end

    // R10: reset mid-run
    idle();
    rst_n = 0;
    #2;
    chk("R10", "async rst full", rx_full, 0);
    chk("R10", "async rst data", rx_data, 0);
    @(negedge clk);
    rst_n = 1;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule